// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block holds the software-visible control and status state of a single-precision floating-point unit. It holds two fields: a 3-bit dynamic rounding mode, and a 5-bit group of sticky exception flags. Software reaches the state through three aliased windows: the whole 32-bit register, the rounding mode alone, and the flags alone. Every access reads the selected window. An access with the write enable set is a swap: the read data shows the value the window held before the clock edge, and the operand is written at that edge.

Two other interfaces serve the floating-point pipeline. The first resolves each instruction's rounding-mode field into an effective mode. The code 111 means "use the dynamic field". The block raises a reserved indication when the mode that results is not one of the five defined modes, so that the decoder can raise an illegal-instruction exception. The second interface is the flag port. Completing arithmetic operations report exception flags there, and the block ORs them into the sticky field. It raises no trap.

Top module: `fp_csr_unit`

## Requirements
- R1: After a synchronous reset the rounding mode is 000 and all flags are clear, so a whole-register read returns 0x00000000.
- R2: A whole-register read returns the rounding mode in bits 7:5 and the flags in bits 4:0: invalid at bit 4, divide-by-zero at bit 3, overflow at bit 2, underflow at bit 1, inexact at bit 0. Bits 31:8 are always zero.
- R3: A whole-register swap returns the old value during the write cycle. It loads the mode from operand bits 7:5 and the flags from operand bits 4:0. Operand bits 31:8 are ignored.
- R4: A mode-only read returns the mode zero-extended in bits 2:0. A mode-only write takes operand bits 2:0 and leaves the flags unchanged.
- R5: A flags-only read returns the flags zero-extended in bits 4:0. A flags-only write takes operand bits 4:0 and leaves the mode unchanged.
- R6: When `flag_valid` is high, `flag_in` is ORed into the flags at the clock edge. A set flag stays set until software writes the flags through the whole or flags-only window.
- R7: If a software write of the flags and a flag report fall in the same cycle, the stored flags become the written value ORed with `flag_in`.
- R8: `eff_rm` is combinational. It equals `inst_rm` when `inst_rm` is not 111, and equals the dynamic mode when `inst_rm` is 111. Mode codes: 000 nearest-even, 001 toward zero, 010 down, 011 up, 100 nearest ties-to-max-magnitude.
- R9: `reserved_rm` is high for a static `inst_rm` of 101 or 110. It is also high when `inst_rm` is 111 and the dynamic mode is 101, 110 or 111. It is low otherwise.
- R10: If several window selects are high, the whole window wins over mode-only, and mode-only wins over flags-only. With no select high, `rd_data` is zero and `wr_en` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_full | input | 1 | Selects the whole-register window |
| sel_mode | input | 1 | Selects the rounding-mode-only window |
| sel_flags | input | 1 | Selects the flags-only window |
| wr_en | input | 1 | Turns the current access into a swap |
| wr_data | input | 32 | Swap operand |
| rd_data | output | 32 | Value of the selected window before the edge |
| flag_valid | input | 1 | Flags reported by a completing operation are valid |
| flag_in | input | 5 | Reported flags, same bit order as the flag field |
| inst_rm | input | 3 | Instruction's rounding-mode field |
| eff_rm | output | 3 | Resolved rounding mode |
| reserved_rm | output | 1 | Resolved rounding mode is reserved |

## Verification
`rd_data`, `eff_rm` and `reserved_rm` are combinational from the current state and inputs, so each is due in the cycle its stimulus is applied. The bench drives inputs just after a rising edge and compares these outputs at mid-cycle. Swaps and flag reports change the state at the next rising edge, so their effect is checked through a read in the following cycle. The bench's model of the state advances at that same edge, which keeps swap-read and read-after-write expectations aligned cycle for cycle.

// File: rtl/fp_csr_pkg.sv
package fp_csr_pkg;

    localparam int CSR_W  = 32;
    localparam int RM_W   = 3;
    localparam int FLAG_W = 5;
    localparam int RM_LSB = FLAG_W;
    localparam int RM_MSB = FLAG_W + RM_W - 1;
    localparam int USED_W = FLAG_W + RM_W;

    typedef logic [RM_W-1:0] rm_t;

    localparam rm_t RM_NEAR_EVEN = 3'b000;
    localparam rm_t RM_ZERO      = 3'b001;
    localparam rm_t RM_DOWN      = 3'b010;
    localparam rm_t RM_UP        = 3'b011;
    localparam rm_t RM_NEAR_MAX  = 3'b100;
    localparam rm_t RM_USE_DYN   = 3'b111;

    // Flag field, invalid in the top bit down to inexact in bit 0.
    typedef struct packed {
        logic invalid;
        logic div_zero;
        logic overflow;
        logic underflow;
        logic inexact;
    } fflags_t;

    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_FULL  = 2'd1,
        WIN_MODE  = 2'd2,
        WIN_FLAGS = 2'd3
    } win_e;

    typedef struct packed {
        logic    full;
        logic    mode;
        logic    flags;
    } wr_strobe_t;

    function automatic logic rm_defined(input rm_t code);
        return code <= RM_NEAR_MAX;
    endfunction

endpackage

// File: rtl/fp_csr_window_decode.sv
module fp_csr_window_decode
    import fp_csr_pkg::*;
#(
    parameter int DATA_W = CSR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_full,
    input  logic              sel_mode,
    input  logic              sel_flags,
    input  logic              wr_en,
    input  rm_t               rm_q,
    input  fflags_t           flags_q,
    output wr_strobe_t        wr_stb,
    output logic [DATA_W-1:0] rd_data
);

    win_e win;

    // Fixed priority: whole register, then mode, then flags.
    always_comb begin
        if (sel_full)       win = WIN_FULL;
        else if (sel_mode)  win = WIN_MODE;
        else if (sel_flags) win = WIN_FLAGS;
        else                win = WIN_NONE;
    end

    always_comb begin
        wr_stb.full  = wr_en && (win == WIN_FULL);
        wr_stb.mode  = wr_en && (win == WIN_MODE);
        wr_stb.flags = wr_en && (win == WIN_FLAGS);
    end

    always_comb begin
        rd_data = '0;
        unique case (win)
            WIN_FULL:  rd_data[USED_W-1:0] = {rm_q, flags_q};
            WIN_MODE:  rd_data[RM_W-1:0]   = rm_q;
            WIN_FLAGS: rd_data[FLAG_W-1:0] = flags_q;
            default:   rd_data = '0;
        endcase
    end

    // R10: at most one window is written per cycle
    p_one_window_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_stb.full, wr_stb.mode, wr_stb.flags}));

    // R10: no select means a zero read
    p_idle_read_r10: assert property (@(posedge clk) disable iff (rst)
        !(sel_full || sel_mode || sel_flags) |-> (rd_data == '0));

endmodule

// File: rtl/fp_csr_fields.sv
module fp_csr_fields
    import fp_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wr_strobe_t wr_stb,
    input  logic [USED_W-1:0] wr_data,
    input  logic       flag_valid,
    input  fflags_t    flag_in,
    output rm_t        rm_q,
    output fflags_t    flags_q
);

    rm_t     rm_d;
    fflags_t flags_base;
    fflags_t flags_d;

    always_comb begin
        rm_d = rm_q;
        if (wr_stb.full)      rm_d = wr_data[RM_MSB:RM_LSB];
        else if (wr_stb.mode) rm_d = wr_data[RM_W-1:0];
    end

    // Software write first, datapath flags merged on top.
    always_comb begin
        flags_base = flags_q;
        if (wr_stb.full || wr_stb.flags) flags_base = wr_data[FLAG_W-1:0];
        flags_d = flag_valid ? (flags_base | flag_in) : flags_base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rm_q    <= RM_NEAR_EVEN;
            flags_q <= '0;
        end else begin
            rm_q    <= rm_d;
            flags_q <= flags_d;
        end
    end

    // R6: without a software flag write no set flag ever clears
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb.full || wr_stb.flags) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R7: reported flags are present after the edge even with a write
    p_merge_r7: assert property (@(posedge clk) disable iff (rst)
        flag_valid |=> ((flags_q & $past(flag_in)) == $past(flag_in)));

    // R5: mode is untouched unless a mode-bearing window is written
    p_mode_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb.full || wr_stb.mode) |=> $stable(rm_q));

    // R4: a mode-only write without flag report leaves flags alone
    p_flags_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_stb.mode && !flag_valid) |=> $stable(flags_q));

endmodule

// File: rtl/fp_csr_rm_resolve.sv
module fp_csr_rm_resolve
    import fp_csr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  rm_t  inst_rm,
    input  rm_t  dyn_rm,
    output rm_t  eff_rm,
    output logic reserved_rm
);

    logic use_dyn;

    always_comb begin
        use_dyn     = (inst_rm == RM_USE_DYN);
        eff_rm      = use_dyn ? dyn_rm : inst_rm;
        reserved_rm = !rm_defined(eff_rm);
    end

    // R8: a static defined mode passes straight through
    p_static_pass_r8: assert property (@(posedge clk) disable iff (rst)
        (inst_rm != RM_USE_DYN && !reserved_rm) |-> (eff_rm == inst_rm));

    // R9: a defined dynamic mode under 111 is never flagged
    p_dyn_ok_r9: assert property (@(posedge clk) disable iff (rst)
        (inst_rm == RM_USE_DYN && dyn_rm <= RM_NEAR_MAX) |-> !reserved_rm);

endmodule

// File: rtl/fp_csr_unit.sv
module fp_csr_unit
    import fp_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_full,
    input  logic              sel_mode,
    input  logic              sel_flags,
    input  logic              wr_en,
    input  logic [CSR_W-1:0]  wr_data,
    output logic [CSR_W-1:0]  rd_data,
    input  logic              flag_valid,
    input  logic [FLAG_W-1:0] flag_in,
    input  logic [RM_W-1:0]   inst_rm,
    output logic [RM_W-1:0]   eff_rm,
    output logic              reserved_rm
);

    wr_strobe_t wr_stb;
    rm_t        rm_q;
    fflags_t    flags_q;

    fp_csr_window_decode #(.DATA_W(CSR_W)) u_decode (
        .clk       (clk),
        .rst       (rst),
        .sel_full  (sel_full),
        .sel_mode  (sel_mode),
        .sel_flags (sel_flags),
        .wr_en     (wr_en),
        .rm_q      (rm_q),
        .flags_q   (flags_q),
        .wr_stb    (wr_stb),
        .rd_data   (rd_data)
    );

    fp_csr_fields u_fields (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data[USED_W-1:0]),
        .flag_valid (flag_valid),
        .flag_in    (flag_in),
        .rm_q       (rm_q),
        .flags_q    (flags_q)
    );

    fp_csr_rm_resolve u_resolve (
        .clk         (clk),
        .rst         (rst),
        .inst_rm     (inst_rm),
        .dyn_rm      (rm_q),
        .eff_rm      (eff_rm),
        .reserved_rm (reserved_rm)
    );

    // R2: the unused upper bits read as zero in every cycle
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_data[CSR_W-1:USED_W] == '0);

    // R3: upper operand bits never reach the read data
    p_upper_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (|wr_data[CSR_W-1:USED_W])) |=> (rd_data[CSR_W-1:USED_W] == '0));

endmodule

// File: tb/tb_fp_csr_unit.sv
module tb_fp_csr_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        sel_full, sel_mode, sel_flags, wr_en, flag_valid;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [4:0]  flag_in;
    logic [2:0]  inst_rm;
    logic [2:0]  eff_rm;
    logic        reserved_rm;

    int checks = 0;
    int errors = 0;

    logic [2:0] m_rm;
    logic [4:0] m_fl;

    always #10 clk = ~clk;

    fp_csr_unit dut (
        .clk(clk), .rst(rst),
        .sel_full(sel_full), .sel_mode(sel_mode), .sel_flags(sel_flags),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .flag_valid(flag_valid), .flag_in(flag_in),
        .inst_rm(inst_rm), .eff_rm(eff_rm), .reserved_rm(reserved_rm)
    );

    function automatic logic [31:0] exp_rd(input logic f, input logic m, input logic g);
        if (f)      return {24'd0, m_rm, m_fl};
        else if (m) return {29'd0, m_rm};
        else if (g) return {27'd0, m_fl};
        else        return 32'd0;
    endfunction

    function automatic logic [2:0] exp_eff(input logic [2:0] irm);
        return (irm == 3'b111) ? m_rm : irm;
    endfunction

    function automatic logic exp_res(input logic [2:0] irm);
        if (irm == 3'b111) return m_rm > 3'b100;
        return (irm == 3'b101) || (irm == 3'b110);
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive after the edge, compare mid-cycle, advance model at the edge.
    task automatic cyc(input string tag, input logic f, input logic m, input logic g,
                       input logic we, input logic [31:0] wd,
                       input logic fv, input logic [4:0] fi, input logic [2:0] irm);
        sel_full = f; sel_mode = m; sel_flags = g; wr_en = we; wr_data = wd;
        flag_valid = fv; flag_in = fi; inst_rm = irm;
        #5;
        check32({tag, " rd_data"}, rd_data, exp_rd(f, m, g));
        check32("R8 eff_rm", {29'd0, eff_rm}, {29'd0, exp_eff(irm)});
        check32("R9 reserved_rm", {31'd0, reserved_rm}, {31'd0, exp_res(irm)});
        @(posedge clk);
        if (we) begin
            if (f) begin m_rm = wd[7:5]; m_fl = wd[4:0]; end
            else if (m) m_rm = wd[2:0];
            else if (g) m_fl = wd[4:0];
        end
        if (fv) m_fl = m_fl | fi;
        #1;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1;
        sel_full = 0; sel_mode = 0; sel_flags = 0; wr_en = 0; wr_data = '0;
        flag_valid = 0; flag_in = '0; inst_rm = '0;
        m_rm = 3'b000; m_fl = 5'b00000;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset value
        cyc("R1", 1, 0, 0, 0, 32'h0, 0, 5'h0, 3'b111);
        // R3 full swap: old value now, upper bits ignored
        cyc("R3", 1, 0, 0, 1, 32'hDEAD_BE6B, 0, 5'h0, 3'b000);
        cyc("R2", 1, 0, 0, 0, 32'h0, 0, 5'h0, 3'b111);
        // R4 mode-only swap with junk upper bits
        cyc("R4", 0, 1, 0, 1, 32'hFFFF_FFF9, 0, 5'h0, 3'b111);
        cyc("R4", 1, 0, 0, 0, 32'h0, 0, 5'h0, 3'b111);
        // R5 flags-only swap
        cyc("R5", 0, 0, 1, 1, 32'hFFFF_FFF4, 0, 5'h0, 3'b010);
        cyc("R5", 1, 0, 0, 0, 32'h0, 0, 5'h0, 3'b001);
        // R6 sticky accumulation
        cyc("R6", 0, 0, 1, 1, 32'h0, 0, 5'h0, 3'b000);
        cyc("R6", 0, 0, 1, 0, 32'h0, 1, 5'h10, 3'b000);
        cyc("R6", 0, 0, 1, 0, 32'h0, 1, 5'h01, 3'b000);
        cyc("R6", 0, 0, 1, 0, 32'h0, 0, 5'h0, 3'b000);
        // R7 write and report together
        cyc("R7", 0, 0, 1, 1, 32'h0000_0002, 1, 5'h08, 3'b000);
        cyc("R7", 0, 0, 1, 0, 32'h0, 0, 5'h0, 3'b000);
        // R9 reserved dynamic values under 111
        cyc("R9", 0, 1, 0, 1, 32'h5, 0, 5'h0, 3'b111);
        cyc("R9", 0, 1, 0, 1, 32'h7, 0, 5'h0, 3'b111);
        cyc("R9", 0, 0, 0, 0, 32'h0, 0, 5'h0, 3'b111);
        cyc("R9", 0, 0, 0, 0, 32'h0, 0, 5'h0, 3'b101);
        cyc("R9", 0, 0, 0, 0, 32'h0, 0, 5'h0, 3'b110);
        cyc("R8", 0, 0, 0, 0, 32'h0, 0, 5'h0, 3'b100);
        // R10 priority and idle write
        cyc("R10", 1, 1, 1, 1, 32'h0000_00A3, 0, 5'h0, 3'b111);
        cyc("R10", 0, 1, 1, 0, 32'h0, 0, 5'h0, 3'b111);
        cyc("R10", 0, 0, 0, 1, 32'hFFFF_FFFF, 0, 5'h0, 3'b111);
        cyc("R10", 1, 0, 0, 0, 32'h0, 0, 5'h0, 3'b111);

        // Random mix over all windows and rounding fields
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] s;
            s = 4'($urandom_range(0, 15));
            cyc(s[0] ? "R3" : (s[1] ? "R4" : (s[2] ? "R5" : "R10")),
                s[0], s[1], s[2], s[3], $urandom(),
                ($urandom_range(0, 3) == 0), 5'($urandom()), 3'($urandom()));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule